// File: doc/BRIEF.md
# Serial Codec Control Bridge

This block sits behind a byte-wide host register port and turns host accesses into serial control traffic for two audio codecs: an output (playback) codec that takes 16-bit command words and an input-level codec that takes 32-bit level frames. The host never writes a word length. A session is framed by side-effect reads: reading one address selects the output codec, reading the data address selects the input codec, and reading a third address ends the session. Inside a session, each host write to the data address carries exactly one serial bit in bit 7 of the written byte.

The block drives one active-low select per codec, a shared serial clock and a shared serial data line. Each accepted bit becomes one clock pulse. Data changes while the clock is low and is sampled by the codec on the rising edge. A one-deep holding register lets the host issue a bit while the previous one is still going out. A `busy` output tells the host when the link cannot take another bit or is still changing sessions.

Typical host traffic is an output codec command such as 0xA007 (power control), 0xA100/0xA103 (reset on/off), 0xA240/0xA24D (clock mode below/at or above 55 kHz), 0xA38D/0xA30D (mute/unmute), or 0xA600/0xA700 plus an 8-bit attenuation code for left/right level. For the input codec it is one 32-bit frame holding the microphone level twice, then the right and the left line level.

Top module: `codec_ctl_bridge`

## Requirements
- R1: During and right after reset both selects are high, the serial clock is low, serial data is low and busy is low.
- R2: With default addresses, a read of address 0xE opens an output-codec session (out_cs_n low) and a read of address 0xB opens an input-codec session (in_cs_n low). The two selects are never low together.
- R3: Each write to address 0xB accepted in an open session produces exactly one serial clock pulse, carrying bit 7 of the written byte. Bits 6..0 have no effect on the line.
- R4: Every serial clock high phase and every low phase before a rising edge lasts at least HALF_CLKS system clocks. Serial data does not change while the clock is high.
- R5: Bits leave in the order they are written, so a host sending MSB first yields a 16-bit output command, or a 32-bit input frame {mic[31:24], mic[23:16], right[15:8], left[7:0]}, intact at the codec.
- R6: A read of address 0xA ends the open session. The select stays low until every bit already accepted has been sent, then goes high.
- R7: Opening a session while one is open (or right after a close) first releases the old select. Both selects stay high for at least GAP_CLKS system clocks before the new select falls.
- R8: A bit written while a bit is shifting and the holding register is empty is kept and sent next. A bit written while the holding register is full is dropped.
- R9: Data writes with no session open produce no serial clock pulse and leave both selects high.
- R10: busy is high whenever a bit is shifting, the holding register is full, or a session change is pending.
- R11: The serial clock pulses only while one select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host register address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data; only bit 7 is used |
| busy | output | 1 | Link cannot take a bit or is changing sessions |
| out_cs_n | output | 1 | Output-codec select, active low |
| in_cs_n | output | 1 | Input-codec select, active low |
| sclk | output | 1 | Serial clock, idle low |
| sdata | output | 1 | Serial data, valid at the rising sclk edge |

## Verification
A serial receiver model rebuilds every frame between a select falling and rising. It compares the frame with what the host meant to send: output commands with different bit patterns (power, reset, clock mode, mute, and both level commands with extreme codes) and input frames with distinct and all-ones/all-zeros bytes. These patterns separate bit-order, select-routing and length errors. The filler in bits 6..0 is set opposite to bit 7 so that a tap on the wrong bit shows up. Back-to-back writes during a pulse tell a working holding register from one that drops or duplicates bits. Writes with no session, a close issued with a bit in flight, and a reopen with no close show whether drop, drain and gap handling work.

// File: rtl/cbr_pkg.sv
// Shared types for the serial codec control bridge.
// Assumes: at most one codec session is physically open at a time.
package cbr_pkg;

    // Which codec a session addresses.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_IN   = 2'd2
    } sel_e;

    // One cycle worth of decoded host activity.
    typedef struct packed {
        logic open_out;
        logic open_in;
        logic close;
        logic bit_wr;
        logic bit_val;
    } bus_evt_t;

endpackage

// File: rtl/cbr_addr_decode.sv
// Host access decoder.
// Turns single-cycle read/write strobes into session and bit events.
// Assumes: strobes last one cycle per access; read data is not needed.
module cbr_addr_decode
    import cbr_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] A_OPEN_OUT = 4'hE,
    parameter logic [ADDR_W-1:0] A_DATA     = 4'hB,
    parameter logic [ADDR_W-1:0] A_CLOSE    = 4'hA
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output bus_evt_t          evt
);

    localparam int SER_BIT = 7;

    // Decode address matches into events.
    always_comb begin
        evt          = '0;
        evt.open_out = bus_rd && (bus_addr == A_OPEN_OUT);
        evt.open_in  = bus_rd && (bus_addr == A_DATA);
        evt.close    = bus_rd && (bus_addr == A_CLOSE);
        evt.bit_wr   = bus_wr && (bus_addr == A_DATA);
        evt.bit_val  = bus_wdata[SER_BIT];
    end

endmodule

// File: rtl/cbr_session_ctl.sv
// Session controller.
// Tracks the session the host asked for (want) and the one shown on the
// select lines (phys). phys only moves while the shifter is drained. Any
// release of a select is followed by GAP_CLKS idle cycles.
// Assumes: the shifter only receives bits while link_ready is high.
module cbr_session_ctl
    import cbr_pkg::*;
#(
    parameter int GAP_CLKS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt,
    input  logic     drained,
    output sel_e     phys_sel,
    output logic     link_ready,
    output logic     sess_busy
);

    localparam int GW = $clog2(GAP_CLKS + 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CLKS);

    sel_e          want_q, phys_q;
    logic          brk_q;
    logic [GW-1:0] gap_q;

    // Apply host requests and walk the select lines toward the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q <= SEL_NONE;
            phys_q <= SEL_NONE;
            brk_q  <= 1'b0;
            gap_q  <= '0;
        end else begin
            if (drained) begin
                if (gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end else if (brk_q) begin
                    brk_q <= 1'b0;
                    if (phys_q != SEL_NONE) begin
                        phys_q <= SEL_NONE;
                        gap_q  <= GAP_LOAD;
                    end
                end else if (phys_q != want_q) begin
                    if (phys_q != SEL_NONE) begin
                        phys_q <= SEL_NONE;
                        gap_q  <= GAP_LOAD;
                    end else begin
                        phys_q <= want_q;
                    end
                end
            end
            // Host requests come last so they win over the engine.
            if (evt.open_out || evt.open_in) begin
                want_q <= evt.open_out ? SEL_OUT : SEL_IN;
                if (want_q != SEL_NONE || phys_q != SEL_NONE)
                    brk_q <= 1'b1;
            end else if (evt.close) begin
                want_q <= SEL_NONE;
            end
        end
    end

    // Link status seen by the top level.
    always_comb begin
        phys_sel   = phys_q;
        link_ready = (want_q != SEL_NONE) && (phys_q == want_q) &&
                     !brk_q && (gap_q == '0);
        sess_busy  = brk_q || (phys_q != want_q) || (gap_q != '0);
    end

endmodule

// File: rtl/cbr_bit_shifter.sv
// Single-bit serialiser with a one-deep holding register.
// Each bit: data set with the clock low, HALF_CLKS cycles low, HALF_CLKS
// high, then the clock falls and the next held bit (if any) is set.
// Assumes: HALF_CLKS >= 1; push is only raised inside an open session.
module cbr_bit_shifter #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    output logic hold_full,
    output logic shifting,
    output logic sclk,
    output logic sdata
);

    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] PH_LOAD = CW'(HALF_CLKS - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_e;

    st_e           st_q;
    logic [CW-1:0] cnt_q;
    logic          hold_v_q, hold_b_q;
    logic          take;

    // A held bit is taken when idle or at the end of a high phase.
    always_comb begin
        take = hold_v_q && ((st_q == ST_IDLE) ||
                            (st_q == ST_HIGH && cnt_q == '0));
    end

    // Holding register: accept when empty, free when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v_q <= 1'b0;
            hold_b_q <= 1'b0;
        end else if (push && !hold_v_q) begin
            hold_v_q <= 1'b1;
            hold_b_q <= push_bit;
        end else if (take) begin
            hold_v_q <= 1'b0;
        end
    end

    // Phase sequencer for the serial clock and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sclk  <= 1'b0;
            sdata <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        sdata <= hold_b_q;
                        st_q  <= ST_LOW;
                        cnt_q <= PH_LOAD;
                    end
                end
                ST_LOW: begin
                    if (cnt_q == '0) begin
                        sclk  <= 1'b1;
                        st_q  <= ST_HIGH;
                        cnt_q <= PH_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt_q == '0) begin
                        sclk <= 1'b0;
                        if (take) begin
                            sdata <= hold_b_q;
                            st_q  <= ST_LOW;
                            cnt_q <= PH_LOAD;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Status toward the top level.
    always_comb begin
        hold_full = hold_v_q;
        shifting  = (st_q != ST_IDLE);
    end

endmodule

// File: rtl/codec_ctl_bridge.sv
// Top level of the serial codec control bridge.
// Wires the decoder, session controller and bit shifter together and maps
// the physical session onto the two active-low selects.
// Assumes: the host waits for busy low before a new session or bit burst.
module codec_ctl_bridge
    import cbr_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] A_OPEN_OUT = 4'hE,
    parameter logic [ADDR_W-1:0] A_DATA     = 4'hB,
    parameter logic [ADDR_W-1:0] A_CLOSE    = 4'hA,
    parameter int                HALF_CLKS  = 4,
    parameter int                GAP_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic              busy,
    output logic              out_cs_n,
    output logic              in_cs_n,
    output logic              sclk,
    output logic              sdata
);

    bus_evt_t evt;
    sel_e     phys_sel;
    logic     link_ready, sess_busy;
    logic     hold_full, shifting, drained, push;

    cbr_addr_decode #(
        .ADDR_W    (ADDR_W),
        .A_OPEN_OUT(A_OPEN_OUT),
        .A_DATA    (A_DATA),
        .A_CLOSE   (A_CLOSE)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .evt      (evt)
    );

    cbr_session_ctl #(
        .GAP_CLKS(GAP_CLKS)
    ) u_sess (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .drained   (drained),
        .phys_sel  (phys_sel),
        .link_ready(link_ready),
        .sess_busy (sess_busy)
    );

    cbr_bit_shifter #(
        .HALF_CLKS(HALF_CLKS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_bit (evt.bit_val),
        .hold_full(hold_full),
        .shifting (shifting),
        .sclk     (sclk),
        .sdata    (sdata)
    );

    // Bit acceptance gate, drain status and select mapping.
    always_comb begin
        push     = evt.bit_wr && link_ready;
        drained  = !shifting && !hold_full;
        busy     = shifting || hold_full || sess_busy;
        out_cs_n = (phys_sel != SEL_OUT);
        in_cs_n  = (phys_sel != SEL_IN);
    end

endmodule

// File: rtl/cbr_checker.sv
// Protocol checker for codec_ctl_bridge, attached with bind.
// Watches only the top-level pins.
module cbr_checker #(
    parameter int HALF_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic out_cs_n,
    input logic in_cs_n,
    input logic sclk,
    input logic sdata
);

    localparam int LW = $clog2(HALF_CLKS + 1) + 1;
    localparam logic [LW-1:0] LMAX = '1;

    logic          prev_sclk;
    logic [LW-1:0] lvl_cnt;

    // Count how long sclk has held its current level (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            lvl_cnt   <= '0;
        end else begin
            prev_sclk <= sclk;
            if (sclk != prev_sclk)
                lvl_cnt <= LW'(1);
            else if (lvl_cnt != LMAX)
                lvl_cnt <= lvl_cnt + 1'b1;
        end
    end

    // R2: never both codecs selected.
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        !(!out_cs_n && !in_cs_n));

    // R11: clock pulses only inside a session.
    a_r11_sclk_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (!out_cs_n || !in_cs_n));

    // R4: data stable while the clock is high.
    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && prev_sclk) |-> (sdata == $past(sdata)));

    // R4: each level held at least HALF_CLKS cycles before changing.
    a_r4_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != prev_sclk) |-> (lvl_cnt >= LW'(HALF_CLKS)));

    // R10: busy while a pulse is on the line.
    a_r10_busy_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

endmodule

bind codec_ctl_bridge cbr_checker #(
    .HALF_CLKS(HALF_CLKS)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .out_cs_n(out_cs_n),
    .in_cs_n (in_cs_n),
    .sclk    (sclk),
    .sdata   (sdata)
);

// File: tb/test_codec_ctl_bridge.sv
// Scoreboard bench: driver pushes expected frames, a serial receiver
// model rebuilds frames from the pins and compares.
module test_codec_ctl_bridge;

    localparam int HALF = 4;
    localparam int GAP  = 4;
    localparam logic [3:0] A_OPEN_OUT = 4'hE;
    localparam logic [3:0] A_DATA     = 4'hB;
    localparam logic [3:0] A_CLOSE    = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata;
    logic       busy, out_cs_n, in_cs_n, sclk, sdata;

    always #4 clk = ~clk;

    codec_ctl_bridge #(
        .HALF_CLKS(HALF),
        .GAP_CLKS (GAP)
    ) i_codec_ctl_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .busy(busy),
        .out_cs_n(out_cs_n), .in_cs_n(in_cs_n), .sclk(sclk), .sdata(sdata)
    );

    typedef struct {
        logic        is_out;
        int          len;
        logic [31:0] word;
        string       tag;
    } frame_t;

    frame_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    int pulse_cnt = 0;
    int min_high = 1000;
    int hcnt = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, string what,
                         logic [31:0] act, logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    // Pulse counter and high-phase width meter.
    always @(posedge sclk) pulse_cnt++;
    always @(negedge clk) begin
        if (sclk) hcnt++;
        else if (hcnt != 0) begin
            if (hcnt < min_high) min_high = hcnt;
            hcnt = 0;
        end
    end

    // Serial receiver model and scoreboard compare.
    initial begin
        forever begin
            logic        is_out;
            int          len;
            logic [31:0] word;
            frame_t      e;
            wait (rst_n === 1'b1 && (out_cs_n === 1'b0 || in_cs_n === 1'b0));
            is_out = !out_cs_n;
            len = 0;
            word = '0;
            while (!(out_cs_n && in_cs_n)) begin
                @(posedge sclk or posedge out_cs_n or posedge in_cs_n);
                if (sclk && !(out_cs_n && in_cs_n)) begin
                    word = {word[30:0], sdata};
                    len++;
                end
            end
            if (exp_q.size() == 0) begin
                check(0, "R5", "unexpected frame", word, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(is_out == e.is_out, e.tag, "frame codec", 32'(is_out), 32'(e.is_out));
                check(len == e.len, e.tag, "frame length", 32'(len), 32'(e.len));
                check(word == e.word, e.tag, "frame word", word, e.word);
            end
        end
    end

    task automatic bus_read(logic [3:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Write one serial bit; filler bits are set opposite to bit 7.
    task automatic bus_bit(logic b);
        @(negedge clk);
        bus_addr = A_DATA; bus_wdata = {b, {7{~b}}}; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Driver: one full session carrying len bits, MSB first.
    task automatic send_frame(logic is_out, int len, logic [31:0] word, string tag);
        frame_t f;
        f.is_out = is_out; f.len = len; f.word = word; f.tag = tag;
        exp_q.push_back(f);
        bus_read(is_out ? A_OPEN_OUT : A_DATA);
        wait_idle();
        check(out_cs_n == !is_out && in_cs_n == is_out, "R2", "selects after open",
              {30'd0, out_cs_n, in_cs_n}, {30'd0, !is_out, is_out});
        for (int i = len - 1; i >= 0; i--) begin
            bus_bit(word[i]);
            wait_idle();
        end
        bus_read(A_CLOSE);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p0;
        int gap_cnt;
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        // R1: reset values
        check({out_cs_n, in_cs_n, sclk, sdata, busy} == 5'b11000, "R1", "reset outputs",
              {27'd0, out_cs_n, in_cs_n, sclk, sdata, busy}, 32'b11000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({out_cs_n, in_cs_n, sclk, busy} == 4'b1100, "R1", "after release",
              {28'd0, out_cs_n, in_cs_n, sclk, busy}, 32'b1100);

        // R9: bit writes with no session
        p0 = pulse_cnt;
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        repeat (20) @(negedge clk);
        check(pulse_cnt == p0, "R9", "pulses with no session", 32'(pulse_cnt), 32'(p0));
        check(out_cs_n && in_cs_n, "R9", "selects with no session",
              {30'd0, out_cs_n, in_cs_n}, 32'b11);

        // R5 / R3: output commands and input frames
        send_frame(1'b1, 16, 32'hA007, "R5");
        send_frame(1'b1, 16, 32'hA100, "R3");
        send_frame(1'b1, 16, 32'hA24D, "R5");
        send_frame(1'b1, 16, 32'hA38D, "R3");
        send_frame(1'b1, 16, 32'hA600 + 32'hC4, "R5");
        send_frame(1'b1, 16, 32'hA700 + 32'hFF, "R5");
        send_frame(1'b0, 32, {8'h12, 8'h12, 8'h34, 8'h56}, "R5");
        send_frame(1'b0, 32, {8'h00, 8'h00, 8'hFF, 8'h81}, "R3");

        // R8: queue one bit during a pulse, drop the next
        begin
            frame_t f;
            f.is_out = 1'b1; f.len = 2; f.word = 32'b10; f.tag = "R8";
            exp_q.push_back(f);
        end
        bus_read(A_OPEN_OUT);
        wait_idle();
        p0 = pulse_cnt;
        bus_bit(1'b1);
        @(posedge sclk);
        bus_bit(1'b0);
        check(busy == 1'b1, "R10", "busy with bit held", 32'(busy), 32'd1);
        bus_bit(1'b1);
        wait_idle();
        check(pulse_cnt == p0 + 2, "R8", "pulse count", 32'(pulse_cnt), 32'(p0 + 2));
        bus_read(A_CLOSE);
        wait_idle();

        // R6: close with a bit still in flight
        begin
            frame_t f;
            f.is_out = 1'b1; f.len = 1; f.word = 32'b1; f.tag = "R6";
            exp_q.push_back(f);
        end
        bus_read(A_OPEN_OUT);
        wait_idle();
        bus_bit(1'b1);
        bus_read(A_CLOSE);
        check(out_cs_n == 1'b0, "R6", "select held while draining", 32'(out_cs_n), 32'd0);
        wait_idle();
        check(out_cs_n == 1'b1, "R6", "select released", 32'(out_cs_n), 32'd1);

        // R7: reopen on the other codec without closing
        begin
            frame_t f;
            f.is_out = 1'b1; f.len = 3; f.word = 32'b101; f.tag = "R7";
            exp_q.push_back(f);
            f.is_out = 1'b0; f.len = 2; f.word = 32'b01; f.tag = "R7";
            exp_q.push_back(f);
        end
        bus_read(A_OPEN_OUT);
        wait_idle();
        bus_bit(1'b1); wait_idle();
        bus_bit(1'b0); wait_idle();
        bus_bit(1'b1); wait_idle();
        bus_read(A_DATA);
        while (!out_cs_n) @(negedge clk);
        gap_cnt = 0;
        while (in_cs_n) begin
            gap_cnt++;
            @(negedge clk);
        end
        check(gap_cnt >= GAP, "R7", "deselect gap", 32'(gap_cnt), 32'(GAP));
        wait_idle();
        bus_bit(1'b0); wait_idle();
        bus_bit(1'b1); wait_idle();
        bus_read(A_CLOSE);
        wait_idle();

        repeat (50) @(negedge clk);
        check(exp_q.size() == 0, "R5", "frames left unseen", 32'(exp_q.size()), 32'd0);
        check(min_high >= HALF, "R4", "shortest high phase", 32'(min_high), 32'(HALF));
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule